// File: doc/BRIEF.md
# Inter-processor interrupt command sequencer

This block issues inter-processor interrupt commands on behalf of a host. It masters a 32-bit memory-mapped register port that reaches an interrupt controller's pair of command words: a high word that carries the destination and a low word whose write launches the message. The host asks for one of four kinds of command: a fixed-vector interrupt, a system-management interrupt, an INIT, or the complete boot handshake (INIT, then startup, then startup again). With each request the host gives a target ID, a vector, a startup page address and a flag that selects broadcast to every other processor.

Each send is wrapped the same way. The block saves the high word. It waits until the controller reports that no earlier message is still in flight. It writes the destination and then the command. It waits until the controller has accepted the command, and then it restores the saved high word. The boot handshake spaces its three sends with delays that are counted on a microsecond tick input. Requests that cannot be encoded are refused without any bus traffic. A status poll that never clears ends with an error, and the bus is released.

Top module: `ipi_sequencer`

## Requirements
- R1: After reset, busy, done, error and bus_req are all 0.
- R2: A send reads the high word, then reads the low word until bit 12 (delivery status) reads 0. It then writes the high word with the target ID in bits 31:24 and zeros below, and only after that writes the low word.
- R3: After the low-word write, the block reads the low word until bit 12 reads 0. It then writes the saved high-word value back and pulses done with error at 0.
- R4: The low-word command has the vector in bits 7:0, the delivery mode in bits 10:8 (fixed 0, system-management 2, INIT 5, startup 6) and bit 14 set to 1. Every other bit is 0. The request kind is encoded as 0 fixed, 1 system-management, 2 INIT and 3 boot. The vector field carries req_vector for fixed commands and is 0 for system-management and INIT commands.
- R5: When req_bcast is 1, bits 19:18 of the low word are 2'b11 and the high word is written as 0, whatever the target ID.
- R6: A boot request sends an INIT command first. After at least INIT_DELAY_US ticks it sends a startup command whose vector is req_addr shifted right by 12. After at least STARTUP_GAP_US more ticks it sends the same startup command again. Each of the three sends follows R2 and R3.
- R7: A boot request whose address is 0x100000 or above, or whose bits 11:0 are not all 0, gives done and error together one cycle after start, with no bus access.
- R8: A directed request, meaning req_bcast is 0, whose target ID is above 0xFF is refused in the same way as in R7.
- R9: If POLL_LIMIT reads in a row all show delivery status set, the block pulses done with error at 1 and makes no further bus access.
- R10: While bus_req is 1 and bus_ack is 0, bus_req, bus_we, bus_addr and bus_wdata hold their values into the next cycle.
- R11: done is a single-cycle pulse, busy is 1 from the cycle after an accepted start until done, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle request strobe, taken only when idle |
| req_kind | input | 2 | Command kind: 0 fixed, 1 system-management, 2 INIT, 3 boot |
| req_target | input | 32 | Target ID; values above 0xFF are refused for directed requests |
| req_vector | input | 8 | Vector for fixed commands |
| req_addr | input | 32 | Startup routine address for boot requests |
| req_bcast | input | 1 | Broadcast to all processors except self |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Valid with done: request refused or poll timed out |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge; read data is valid with it |
| bus_rdata | input | 32 | Read data |

## Verification
The assertions assume that bus_ack is a single-cycle pulse that comes only while bus_req is high, and that bus_rdata is meaningful only in the cycle of bus_ack. The bench's controller model acknowledges each access one cycle after the request appears and drops the acknowledge in the next cycle, so it never acknowledges twice. Start pulses are driven only between clock edges, and tick_us is a one-cycle pulse every fourth cycle, so the delay windows can be counted exactly.

// File: rtl/ipi_sequencer.sv
module ipi_sequencer #(
  parameter int ADDR_W          = 12,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter int INIT_DELAY_US   = 10,
  parameter int STARTUP_GAP_US  = 200,
  parameter int POLL_LIMIT      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_target,
  input  logic [7:0]        req_vector,
  input  logic [31:0]       req_addr,
  input  logic              req_bcast,
  input  logic              tick_us,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);

  localparam int WMAX = (INIT_DELAY_US > STARTUP_GAP_US) ? INIT_DELAY_US : STARTUP_GAP_US;
  localparam int WW   = $clog2(WMAX + 2);
  localparam int PW   = $clog2(POLL_LIMIT + 1);
  localparam int STAT_BIT = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_RDHI, S_POLL1, S_WRHI, S_WRLO, S_POLL2, S_REST, S_WAIT
  } st_t;

  st_t         st;
  logic [1:0]  kind_q;
  logic        bcast_q;
  logic [7:0]  tgt_q, vec_q, page_q;
  logic [1:0]  step_q;
  logic [31:0] saved_hi;
  logic [PW-1:0] poll_cnt;
  logic [WW-1:0] wait_cnt;
  logic        done_q, err_q;

  logic        bad_req, stat_set, poll_out, wait_over;
  logic [2:0]  mode;
  logic [7:0]  vfield;
  logic [31:0] cmd_lo, cmd_hi;

  assign bad_req = (!req_bcast && req_target > 32'hFF) ||
                   (req_kind == 2'd3 && (req_addr[31:20] != 12'd0 || req_addr[11:0] != 12'd0));

  always_comb begin
    case (kind_q)
      2'd0:    mode = 3'd0;
      2'd1:    mode = 3'd2;
      2'd2:    mode = 3'd5;
      default: mode = (step_q == 2'd0) ? 3'd5 : 3'd6;
    endcase
  end

  assign vfield = (kind_q == 2'd0) ? vec_q :
                  (kind_q == 2'd3 && step_q != 2'd0) ? page_q : 8'd0;
  assign cmd_lo = {12'd0, bcast_q ? 2'b11 : 2'b00, 3'd0, 1'b1, 3'd0, mode, vfield};
  assign cmd_hi = bcast_q ? 32'd0 : {tgt_q, 24'd0};

  assign stat_set  = bus_rdata[STAT_BIT];
  assign poll_out  = (32'(poll_cnt) == POLL_LIMIT - 1);
  assign wait_over = (step_q == 2'd0) ? (32'(wait_cnt) >= INIT_DELAY_US)
                                      : (32'(wait_cnt) >= STARTUP_GAP_US);

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign bus_req   = (st != S_IDLE) && (st != S_WAIT);
  assign bus_we    = (st == S_WRHI) || (st == S_WRLO) || (st == S_REST);
  assign bus_addr  = (st == S_RDHI || st == S_WRHI || st == S_REST) ? HI_OFF : LO_OFF;
  assign bus_wdata = (st == S_WRHI) ? cmd_hi :
                     (st == S_WRLO) ? cmd_lo :
                     (st == S_REST) ? saved_hi : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= 2'd0;
      bcast_q  <= 1'b0;
      tgt_q    <= 8'd0;
      vec_q    <= 8'd0;
      page_q   <= 8'd0;
      step_q   <= 2'd0;
      saved_hi <= 32'd0;
      poll_cnt <= '0;
      wait_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          if (bad_req) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            kind_q  <= req_kind;
            bcast_q <= req_bcast;
            tgt_q   <= req_bcast ? 8'd0 : req_target[7:0];
            vec_q   <= req_vector;
            page_q  <= req_addr[19:12];
            step_q  <= 2'd0;
            st      <= S_RDHI;
          end
        end
        S_RDHI: if (bus_ack) begin
          saved_hi <= bus_rdata;
          poll_cnt <= '0;
          st       <= S_POLL1;
        end
        S_POLL1, S_POLL2: if (bus_ack) begin
          if (!stat_set) begin
            st <= (st == S_POLL1) ? S_WRHI : S_REST;
          end else if (poll_out) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_WRHI: if (bus_ack) st <= S_WRLO;
        S_WRLO: if (bus_ack) begin
          poll_cnt <= '0;
          st       <= S_POLL2;
        end
        S_REST: if (bus_ack) begin
          if (kind_q == 2'd3 && step_q != 2'd2) begin
            wait_cnt <= '0;
            st       <= S_WAIT;
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (wait_over) begin
            step_q <= step_q + 1'b1;
            st     <= S_RDHI;
          end else if (tick_us) begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !error && !bus_req);

  assert_lo_write_then_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we && bus_addr == LO_OFF) |=> bus_req && !bus_we && bus_addr == LO_OFF);

  assert_level_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == LO_OFF) |-> bus_wdata[14] && bus_wdata[31:20] == 12'd0);

  assert_bcast_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == LO_OFF && bus_wdata[19:18] == 2'b11) |-> cmd_hi == 32'd0);

  assert_refuse_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start && bad_req) |=> done && error && !bus_req);

  assert_error_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done && !bus_req);

  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/ipi_sequencer_test.sv
module ipi_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] HI = 12'h310;
  localparam logic [11:0] LO = 12'h300;
  localparam int INIT_D = 10;
  localparam int GAP_D  = 200;
  localparam int PLIM   = 64;

  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_bcast = 0, tick_us = 0;
  logic [1:0] req_kind = 0;
  logic [31:0] req_target = 0, req_addr = 0;
  logic [7:0] req_vector = 0;
  logic busy, done, error, bus_req, bus_we, bus_ack = 0;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;

  ipi_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
    .req_target(req_target), .req_vector(req_vector), .req_addr(req_addr),
    .req_bcast(req_bcast), .tick_us(tick_us), .busy(busy), .done(done),
    .error(error), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int tick_ph = 0, ticks = 0;
  int busy_left = 0, busy_cfg = 0, done_cnt = 0;
  logic [31:0] hi_reg = 0, lo_reg = 0;
  int log_n = 0;
  logic        log_we [0:255];
  logic [11:0] log_a  [0:255];
  logic [31:0] log_d  [0:255];
  int          log_t  [0:255];

  always @(posedge clk) begin
    tick_us <= (tick_ph == 3);
    tick_ph <= (tick_ph + 1) % 4;
    if (tick_us) ticks <= ticks + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) bus_ack <= 0;
    else if (bus_req && !bus_ack) begin
      bus_ack <= 1;
      if (log_n < 256) begin
        log_we[log_n] <= bus_we; log_a[log_n] <= bus_addr;
        log_d[log_n] <= bus_wdata; log_t[log_n] <= ticks;
        log_n <= log_n + 1;
      end
      if (bus_we) begin
        if (bus_addr == HI) hi_reg <= bus_wdata;
        else begin lo_reg <= bus_wdata; busy_left <= busy_cfg; end
      end else begin
        if (bus_addr == HI) bus_rdata <= hi_reg;
        else begin
          bus_rdata <= (lo_reg & ~32'h1000) | ((busy_left != 0) ? 32'h1000 : 32'h0);
          if (busy_left != 0) busy_left <= busy_left - 1;
        end
      end
    end else bus_ack <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  task automatic issue(input logic [1:0] k, input logic [31:0] t, input logic [7:0] v,
                       input logic [31:0] a, input logic b, output logic err);
    @(negedge clk);
    log_n = 0;
    req_kind = k; req_target = t; req_vector = v; req_addr = a; req_bcast = b;
    req_start = 1;
    @(negedge clk);
    req_start = 0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    err = error;
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic expect_send(input int base, input logic [31:0] hiw, input logic [31:0] low,
                             input logic [31:0] saved, input int pre, input int post);
    int i = base;
    chk("R2 read hi", {log_we[i], 19'd0, log_a[i]}, {1'b0, 19'd0, HI}); i++;
    for (int p = 0; p <= pre; p++) begin
      chk("R2 poll lo", {log_we[i], 19'd0, log_a[i]}, {1'b0, 19'd0, LO}); i++;
    end
    chk("R2 write hi addr", {log_we[i], 19'd0, log_a[i]}, {1'b1, 19'd0, HI});
    chk("R2 hi target", log_d[i], hiw); i++;
    chk("R2 write lo addr", {log_we[i], 19'd0, log_a[i]}, {1'b1, 19'd0, LO});
    chk("R4 lo command", log_d[i], low); i++;
    for (int p = 0; p <= post; p++) begin
      chk("R3 poll lo after", {log_we[i], 19'd0, log_a[i]}, {1'b0, 19'd0, LO}); i++;
    end
    chk("R3 restore hi addr", {log_we[i], 19'd0, log_a[i]}, {1'b1, 19'd0, HI});
    chk("R3 restore value", log_d[i], saved);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 error", {31'd0, error}, 0);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
  endtask

  task automatic t_fixed;
    logic e;
    int d0;
    hi_reg = 32'hA5000000; busy_left = 1; busy_cfg = 2;
    d0 = done_cnt;
    fork
      issue(2'd0, 32'h3C, 8'h41, 0, 0, e);
      begin
        repeat (5) @(negedge clk);
        chk("R11 busy mid", {31'd0, busy}, 1);
        req_kind = 2'd2; req_start = 1;
        @(negedge clk); req_start = 0;
      end
    join
    chk("R3 no error", {31'd0, e}, 0);
    chk("R11 log length", log_n, 9);
    chk("R11 one done", done_cnt - d0, 1);
    expect_send(0, 32'h3C000000, 32'h00004041, 32'hA5000000, 1, 2);
  endtask

  task automatic t_smi_bcast;
    logic e;
    hi_reg = 32'h12345678; busy_left = 0; busy_cfg = 0;
    issue(2'd1, 32'h7FF, 8'h99, 0, 1, e);
    chk("R5 no error", {31'd0, e}, 0);
    chk("R5 log length", log_n, 6);
    expect_send(0, 32'h0, 32'h000C4200, 32'h12345678, 0, 0);
  endtask

  task automatic t_init;
    logic e;
    hi_reg = 32'h0; busy_cfg = 1;
    issue(2'd2, 32'hFF, 8'h55, 0, 0, e);
    chk("R4 init no error", {31'd0, e}, 0);
    expect_send(0, 32'hFF000000, 32'h00004500, 32'h0, 0, 1);
  endtask

  task automatic t_boot;
    logic e;
    int dt;
    hi_reg = 32'h0B000000; busy_cfg = 1;
    issue(2'd3, 32'h07, 8'h00, 32'h0009F000, 0, e);
    chk("R6 no error", {31'd0, e}, 0);
    chk("R6 log length", log_n, 21);
    expect_send(0,  32'h07000000, 32'h00004500, 32'h0B000000, 0, 1);
    expect_send(7,  32'h07000000, 32'h0000469F, 32'h0B000000, 0, 1);
    expect_send(14, 32'h07000000, 32'h0000469F, 32'h0B000000, 0, 1);
    dt = log_t[10] - log_t[3];
    chk("R6 init delay min", {31'd0, dt >= INIT_D}, 1);
    chk("R6 init delay max", {31'd0, dt <= INIT_D + 6}, 1);
    dt = log_t[17] - log_t[10];
    chk("R6 gap min", {31'd0, dt >= GAP_D}, 1);
    chk("R6 gap max", {31'd0, dt <= GAP_D + 6}, 1);
  endtask

  task automatic refuse(input string req, input logic [1:0] k, input logic [31:0] t,
                        input logic [31:0] a, input logic b);
    @(negedge clk);
    log_n = 0;
    req_kind = k; req_target = t; req_addr = a; req_bcast = b; req_start = 1;
    @(negedge clk);
    req_start = 0;
    chk(req, {30'd0, done, error}, 32'd3);
    repeat (4) @(negedge clk);
    chk(req, log_n, 0);
    chk(req, {31'd0, busy}, 0);
  endtask

  task automatic t_timeout;
    logic e;
    busy_left = 1000; busy_cfg = 0;
    issue(2'd0, 32'h01, 8'h20, 0, 0, e);
    chk("R9 error", {31'd0, e}, 1);
    chk("R9 access count", log_n, 1 + PLIM);
    chk("R9 last is read", {31'd0, log_we[log_n-1]}, 0);
    repeat (5) @(negedge clk);
    chk("R9 bus quiet", log_n, 1 + PLIM);
    busy_left = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_fixed();
    t_smi_bcast();
    t_init();
    t_boot();
    refuse("R7 addr high", 2'd3, 32'h1, 32'h00100000, 0);
    refuse("R7 addr unaligned", 2'd3, 32'h1, 32'h0009F800, 0);
    refuse("R8 target high", 2'd0, 32'h100, 32'h0, 0);
    t_timeout();
    summary();
  end
endmodule